// File: doc/BRIEF.md
# Read Response Latency Histogram Monitor

This block watches the request and response channels of an AXI read port without driving any of them. For every read data beat it measures how many clock cycles have passed since the address handshake of the request that beat belongs to, and sorts the beat into one of six latency ranges. The first range is wide (0 to 127 cycles). Four further ranges are 64 cycles wide each (128–191, 192–255, 256–319, 320–383). The last range collects every latency of 384 cycles or more.

Only the first five ranges have counters of their own. The sixth value is computed on read as the total beat count minus the sum of the five counted ranges. Besides the histogram, the block counts every transferred read beat and every cycle in which a request is presented but not accepted. Software reads the counters through a small combinational register port and zeroes them with a synchronous clear. Bandwidth is left to software as beats times the bus width in bytes, so the data width does not appear in the hardware.

Requests are matched to responses per ID in issue order. Each ID has a short queue of entries, and each entry holds an age counter that saturates at 384. Every beat of a burst is timed against its own request, and the entry is retired by the beat that closes the burst.

Top module: `rdlat_hist_mon`

## Requirements
- R1: The latency of a beat is the number of clock edges from the edge that samples its request handshake (ar_valid and ar_ready high) to the edge that samples the beat handshake (r_valid and r_ready high), so the minimum is 1. Latencies 0–127 increment register 0, 128–191 register 1, 192–255 register 2, 256–319 register 3, 320–383 register 4, and 384 or more increment none of these.
- R2: Requests are matched per ID (ar_id against r_id) in issue order. All beats of a burst use the request at the head of their ID's queue, that request is retired by the beat with r_last high, and traffic on one ID does not disturb the timing of another ID.
- R3: The total-beat counter (register 6) increments by one in every cycle with an r_valid and r_ready handshake, whether or not a matching request is pending.
- R4: Register 5 reads as the total-beat count minus the sum of registers 0 to 4, modulo 2^CNT_W.
- R5: The stall counter (register 7) increments in every cycle in which ar_valid is high and ar_ready is low.
- R6: Every counter saturates at 2^CNT_W−1 and stays there instead of wrapping.
- R7: A high clr at a clock edge sets every counter to zero at that edge and overrides any increment in the same cycle. Pending requests and their ages are not affected by clr.
- R8: If a request handshake and a beat handshake on the same ID happen in the same cycle, the beat is matched to the oldest request that was already pending, and the new request is only queued. If no request was pending, the beat counts only in the total.
- R9: The register port is combinational. rd_data presents, for rd_addr 0 to 7, the five range counters, the derived overflow value, the total-beat count and the stall count, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| ar_valid | input | 1 | Read request valid (observed) |
| ar_ready | input | 1 | Read request ready (observed) |
| ar_id | input | ID_W | Read request ID (observed) |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_id | input | ID_W | Read data ID (observed) |
| r_last | input | 1 | Last beat of a burst (observed) |
| rd_addr | input | 3 | Register select |
| rd_data | output | CNT_W | Selected register value |

## Verification
The bench sweeps a single-beat read over every latency from 1 to 420 cycles. Each boundary (127/128, 191/192, 255/256, 319/320, 383/384) is therefore crossed exactly. An off-by-one in the age origin or in a range edge would show up as a count that lands one register away. A burst scenario interleaves two IDs and queues a second request behind a multi-beat burst. A design that re-timed later beats, retired the entry on the first beat, or shared queues across IDs would place beats in the wrong ranges. Separate cases cover a request and a beat that coincide on the same ID, both with and without an older pending request, where a design that matched the new request would report the wrong range for the following beat. The remaining cases cover a clear that coincides with a stall, a stall run long enough to reach saturation, and pending ages that must survive a clear.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

    // Latency binning is fixed: a wide first range, then 64-cycle ranges.
    localparam int FIRST_END   = 128;
    localparam int STEP_SH     = 6;
    localparam int NUM_BINS    = 5;
    localparam int AGE_SAT     = FIRST_END + (NUM_BINS - 1) * (1 << STEP_SH);
    localparam int AGE_W       = $clog2(AGE_SAT + 1);
    localparam int BIN_IDX_W   = 3;
    localparam int REG_ADDR_W  = 3;

    typedef enum logic [BIN_IDX_W-1:0] {
        LAT_B0  = 3'd0,
        LAT_B1  = 3'd1,
        LAT_B2  = 3'd2,
        LAT_B3  = 3'd3,
        LAT_B4  = 3'd4,
        LAT_OVF = 3'd5
    } lat_bin_e;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_B0    = 3'd0,
        REG_B1    = 3'd1,
        REG_B2    = 3'd2,
        REG_B3    = 3'd3,
        REG_B4    = 3'd4,
        REG_OVF   = 3'd5,
        REG_TOTAL = 3'd6,
        REG_STALL = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/rdlat_age_fifo.sv
// In-order queue of outstanding requests for one ID; each slot holds an
// age that counts clock edges since its request and saturates at AGE_SAT.
module rdlat_age_fifo
    import rdlat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [AGE_W-1:0] head_age,
    output logic             head_vld,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_SAT);

    logic [AGE_W-1:0] age_q [DEPTH];
    logic [DEPTH-1:0] slot_v_q;
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [PTR_W:0]   cnt_q;
    logic             push_ok, pop_ok;

    assign full     = (cnt_q == (PTR_W+1)'(DEPTH));
    assign head_vld = (cnt_q != '0);
    assign head_age = age_q[rptr_q];
    assign push_ok  = push && !full;
    assign pop_ok   = pop && head_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == PTR_W'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            cnt_q <= cnt_q + (PTR_W+1)'(push_ok) - (PTR_W+1)'(pop_ok);
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q[s]    <= '0;
                slot_v_q[s] <= 1'b0;
            end else if (push_ok && wptr_q == PTR_W'(s)) begin
                // Age 1 at the next edge after the request handshake.
                age_q[s]    <= AGE_W'(1);
                slot_v_q[s] <= 1'b1;
            end else if (pop_ok && rptr_q == PTR_W'(s)) begin
                slot_v_q[s] <= 1'b0;
            end else if (slot_v_q[s] && age_q[s] != AGE_MAX) begin
                age_q[s] <= age_q[s] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rdlat_bin_sel.sv
// Maps a beat's age to one latency range and raises that range's increment.
module rdlat_bin_sel
    import rdlat_pkg::*;
(
    input  logic [AGE_W-1:0]    age,
    input  logic                en,
    output lat_bin_e            bin,
    output logic [NUM_BINS-1:0] inc
);
    localparam logic [AGE_W-1:0] LO_END = AGE_W'(FIRST_END);
    localparam logic [AGE_W-1:0] HI_END = AGE_W'(AGE_SAT);
    localparam logic [AGE_W-1:0] OFFSET = AGE_W'(FIRST_END - (1 << STEP_SH));

    logic [AGE_W-1:0] shifted;

    always_comb begin
        shifted = (age - OFFSET) >> STEP_SH;
        if (age < LO_END)       bin = LAT_B0;
        else if (age >= HI_END) bin = LAT_OVF;
        else                    bin = lat_bin_e'(shifted[BIN_IDX_W-1:0]);
    end

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_inc
        assign inc[b] = en && (bin == lat_bin_e'(b));
    end

endmodule

// File: rtl/rdlat_sat_ctr.sv
// Saturating event counter with synchronous clear that wins over increment.
module rdlat_sat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= '0;
        else if (inc && q != '1)    q <= q + 1'b1;
    end
endmodule

// File: rtl/rdlat_hist_mon.sv
module rdlat_hist_mon
    import rdlat_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int DEPTH = 4,
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  ar_valid,
    input  logic                  ar_ready,
    input  logic [ID_W-1:0]       ar_id,
    input  logic                  r_valid,
    input  logic                  r_ready,
    input  logic [ID_W-1:0]       r_id,
    input  logic                  r_last,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]      rd_data
);
    localparam int NUM_IDS = 1 << ID_W;
    localparam int SUM_W   = CNT_W + BIN_IDX_W;

    logic                ar_hs, r_hs, stall_ev;
    logic [AGE_W-1:0]    head_age [NUM_IDS];
    logic [NUM_IDS-1:0]  head_vld;
    logic [NUM_IDS-1:0]  fifo_full;
    logic [AGE_W-1:0]    sel_age;
    logic                sel_vld;
    lat_bin_e            beat_bin;
    logic [NUM_BINS-1:0] bin_inc;
    logic [CNT_W-1:0]    bin_q [NUM_BINS];
    logic [CNT_W-1:0]    total_q, stall_q, ovf_val;
    logic [SUM_W-1:0]    bin_sum;

    assign ar_hs    = ar_valid && ar_ready;
    assign r_hs     = r_valid && r_ready;
    assign stall_ev = ar_valid && !ar_ready;

    // One request queue per ID. The head is read before this cycle's push,
    // so a coinciding request never serves a coinciding beat.
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
        logic push_i, pop_i;
        assign push_i = ar_hs && (ar_id == ID_W'(g));
        assign pop_i  = r_hs && r_last && (r_id == ID_W'(g));
        rdlat_age_fifo #(.DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_i),
            .pop      (pop_i),
            .head_age (head_age[g]),
            .head_vld (head_vld[g]),
            .full     (fifo_full[g])
        );
    end

    assign sel_age = head_age[r_id];
    assign sel_vld = head_vld[r_id];

    rdlat_bin_sel u_bin (
        .age (sel_age),
        .en  (r_hs && sel_vld),
        .bin (beat_bin),
        .inc (bin_inc)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        rdlat_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (bin_inc[b]),
            .q     (bin_q[b])
        );
    end

    rdlat_sat_ctr #(.W(CNT_W)) u_total (
        .clk (clk), .rst_n (rst_n), .clr (clr), .inc (r_hs), .q (total_q)
    );

    rdlat_sat_ctr #(.W(CNT_W)) u_stall (
        .clk (clk), .rst_n (rst_n), .clr (clr), .inc (stall_ev), .q (stall_q)
    );

    // Overflow range has no counter: it is what the total leaves over.
    always_comb begin
        bin_sum = '0;
        for (int b = 0; b < NUM_BINS; b++) bin_sum = bin_sum + SUM_W'(bin_q[b]);
        ovf_val = total_q - bin_sum[CNT_W-1:0];
    end

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            REG_B0:    rd_data = bin_q[0];
            REG_B1:    rd_data = bin_q[1];
            REG_B2:    rd_data = bin_q[2];
            REG_B3:    rd_data = bin_q[3];
            REG_B4:    rd_data = bin_q[4];
            REG_OVF:   rd_data = ovf_val;
            REG_TOTAL: rd_data = total_q;
            REG_STALL: rd_data = stall_q;
            default:   rd_data = '0;
        endcase
    end

    logic unused_bin;
    assign unused_bin = ^beat_bin;

endmodule

// File: rtl/rdlat_hist_mon_chk.sv
module rdlat_hist_mon_chk
    import rdlat_pkg::*;
#(
    parameter int ID_W    = 2,
    parameter int CNT_W   = 32,
    parameter int NUM_IDS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                ar_valid,
    input logic                ar_ready,
    input logic [ID_W-1:0]     ar_id,
    input logic                r_valid,
    input logic                r_ready,
    input logic [NUM_BINS-1:0] bin_inc,
    input logic [CNT_W-1:0]    total_q,
    input logic [CNT_W-1:0]    stall_q,
    input logic [NUM_IDS-1:0]  fifo_full
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R1: a beat lands in at most one counted range.
    p_one_bin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bin_inc));

    // R1: no range moves without a beat handshake.
    p_bin_needs_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_inc != '0) |-> (r_valid && r_ready));

    // R2: accepted requests always find room in their ID queue.
    p_queue_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |-> !fifo_full[ar_id]);

    // R3: each beat adds exactly one to the total.
    p_total_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && !clr && total_q != CMAX) |=> (total_q == $past(total_q) + 1'b1));

    // R5: each refused request cycle adds one to the stall count.
    p_stall_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready && !clr && stall_q != CMAX) |=> (stall_q == $past(stall_q) + 1'b1));

    // R6: a saturated counter holds.
    p_stall_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && stall_q == CMAX) |=> (stall_q == CMAX));

    // R7: clear empties the counters at the next edge.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total_q == '0 && stall_q == '0));

endmodule

bind rdlat_hist_mon rdlat_hist_mon_chk #(
    .ID_W    (ID_W),
    .CNT_W   (CNT_W),
    .NUM_IDS (NUM_IDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ar_valid  (ar_valid),
    .ar_ready  (ar_ready),
    .ar_id     (ar_id),
    .r_valid   (r_valid),
    .r_ready   (r_ready),
    .bin_inc   (bin_inc),
    .total_q   (total_q),
    .stall_q   (stall_q),
    .fifo_full (fifo_full)
);

// File: tb/rdlat_hist_mon_tb.sv
`timescale 1ns/1ps
module rdlat_hist_mon_tb;
    localparam int ID_W  = 2;
    localparam int DEPTH = 4;
    localparam int CNT_W = 9;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             ar_valid = 1'b0, ar_ready = 1'b0;
    logic [ID_W-1:0]  ar_id = '0;
    logic             r_valid = 1'b0, r_ready = 1'b0, r_last = 1'b0;
    logic [ID_W-1:0]  r_id = '0;
    logic [2:0]       rd_addr = '0;
    logic [CNT_W-1:0] rd_data;

    int tests = 0;
    int fails = 0;
    int exp_bin [6];
    int exp_total;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rdlat_hist_mon #(.ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 3'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic idle();
        ar_valid = 0; ar_ready = 0; ar_id = '0;
        r_valid = 0; r_ready = 0; r_id = '0; r_last = 0; clr = 0;
    endtask

    task automatic do_ar(input int id);
        ar_valid = 1; ar_ready = 1; ar_id = ID_W'(id);
    endtask

    task automatic do_r(input int id, input bit last);
        r_valid = 1; r_ready = 1; r_id = ID_W'(id); r_last = last;
    endtask

    task automatic do_clear();
        @(negedge clk); idle(); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    // Expected range from the latency in cycles (R1 boundaries).
    function automatic int lat_bin(input int lat);
        if (lat < 128) return 0;
        if (lat >= 384) return 5;
        return (lat - 128) / 64 + 1;
    endfunction

    task automatic check_all(input string tag, input int b0, input int b1, input int b2,
                             input int b3, input int b4, input int ovf, input int tot, input int stl);
        int v;
        int e [8];
        e[0] = b0; e[1] = b1; e[2] = b2; e[3] = b3; e[4] = b4;
        e[5] = ovf; e[6] = tot; e[7] = stl;
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk($sformatf("%s reg%0d", tag, a), v, e[a]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int v;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // Reset state (R9 register map, all zero)
        check_all("R9 reset", 0, 0, 0, 0, 0, 0, 0, 0);

        // R1 sweep over every latency 1..420, one single-beat burst each (R3, R4)
        for (int i = 0; i < 6; i++) exp_bin[i] = 0;
        exp_total = 0;
        for (int lat = 1; lat <= 420; lat++) begin
            int b;
            @(negedge clk); idle(); do_ar(0);
            @(negedge clk); idle();
            repeat (lat - 1) @(negedge clk);
            do_r(0, 1'b1);
            @(negedge clk); idle();
            b = lat_bin(lat);
            exp_bin[b]++;
            exp_total++;
            rd(b, v);
            chk($sformatf("R1 lat %0d range %0d", lat, b), v, exp_bin[b]);
            rd(6, v);
            chk($sformatf("R3 total after lat %0d", lat), v, exp_total);
        end
        check_all("R4 sweep", 127, 64, 64, 64, 64, 37, 420, 0);

        do_clear();
        check_all("R7 clear", 0, 0, 0, 0, 0, 0, 0, 0);

        // R2 bursts and interleaved IDs
        for (int c = 0; c <= 215; c++) begin
            @(negedge clk); idle();
            case (c)
                0:   do_ar(0);
                2:   do_ar(1);
                5:   do_ar(0);
                100: do_r(0, 1'b0);
                130: do_r(0, 1'b0);
                150: do_r(1, 1'b1);
                200: do_r(0, 1'b1);
                210: do_r(0, 1'b1);
                default: ;
            endcase
        end
        @(negedge clk); idle();
        check_all("R2 bursts", 1, 2, 2, 0, 0, 0, 5, 0);

        do_clear();

        // R8 coinciding request and beat on one ID
        for (int c = 0; c <= 155; c++) begin
            @(negedge clk); idle();
            case (c)
                0:   do_ar(3);
                50:  begin do_ar(3); do_r(3, 1'b1); end
                60:  begin do_ar(2); do_r(2, 1'b1); end
                70:  do_r(2, 1'b1);
                150: do_r(3, 1'b1);
                default: ;
            endcase
        end
        @(negedge clk); idle();
        check_all("R8 same cycle", 3, 0, 0, 0, 0, 1, 4, 0);

        do_clear();

        // R5 stall counting
        for (int c = 0; c <= 51; c++) begin
            @(negedge clk); idle();
            if (c <= 36) begin ar_valid = 1; ar_ready = 0; end
            else if (c >= 47) begin ar_valid = 0; ar_ready = 1; end
        end
        @(negedge clk); idle();
        check_all("R5 stall", 0, 0, 0, 0, 0, 0, 0, 37);

        do_clear();

        // R7 clear beats a coinciding stall; pending age survives clear
        for (int c = 0; c <= 200; c++) begin
            @(negedge clk); idle();
            if (c == 0) do_ar(1);
            else if (c <= 9) begin ar_valid = 1; ar_ready = 0; ar_id = 2'd2; end
            if (c == 9) clr = 1;
            if (c == 200) do_r(1, 1'b1);
        end
        @(negedge clk); idle();
        check_all("R7 clear priority", 0, 0, 1, 0, 0, 0, 1, 0);

        do_clear();

        // R6 saturation of the stall counter
        @(negedge clk); idle(); ar_valid = 1; ar_ready = 0;
        repeat (600) @(negedge clk);
        idle();
        rd(7, v);
        chk("R6 stall saturates", v, CMAX);
        rd(6, v);
        chk("R6 total untouched", v, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule